// File: doc/BRIEF.md
# Pipeline operand bypass and load interlock control

This block is the combinational hazard controller for a five-stage in-order integer pipeline. It compares the register numbers carried by the instructions in ID, EX, MEM and WB. From those comparisons it chooses where each consumer takes its operand from:

- the two ALU inputs in EX;
- the store-data input to data memory in MEM;
- the two operands of the zero-detect branch comparator in ID.

An operand comes either from the register file or from a younger result still in flight. A younger result is either the ALU output latched after EX, or the value latched after MEM, which is an ALU result or loaded data.

The block also raises a single stall request when the instruction in ID needs a value that cannot be bypassed in time. While the request is high, the surrounding pipeline holds its PC and the IF/ID register, and loads a bubble into the ID/EX register. Older instructions keep moving. Register 0 is hard-wired to zero and never counts as a producer.

Top module: `hazard_fwd_unit`

## Requirements
- R1: An ALU operand select (`alu_a_sel_o` for source 1, `alu_b_sel_o` for source 2 of the EX instruction) is 2'b10 when the MEM-stage instruction writes (`mem_we_i`=1) a nonzero `mem_rd_i` equal to that source.
- R2: Otherwise that select is 2'b01 when the WB-stage instruction writes (`wb_we_i`=1) a nonzero `wb_rd_i` equal to that source.
- R3: When both the MEM and the WB producers match the same source, the select is 2'b10, because the younger MEM-stage result wins.
- R4: A producer whose write flag is 0, or whose destination is register 0, never causes forwarding. When no producer matches, a select is 2'b00. The value 2'b11 never appears.
- R5: `st_data_sel_o` is 1 exactly when the WB instruction writes a nonzero `wb_rd_i` equal to the store-data source `mem_rs2_i` of the MEM instruction. Otherwise it is 0.
- R6: The branch comparator selects `br_a_sel_o` and `br_b_sel_o` follow the encoding and priority of R1 to R4. They are applied to the ID sources `id_rs1_i` and `id_rs2_i`, with the MEM and WB producers.
- R7: `stall_o` is 1 when the EX instruction is a load (`ex_load_i`=1) that writes a nonzero `ex_rd_i` equal to `id_rs1_i` or `id_rs2_i`.
- R8: `stall_o` is 1 when the ID instruction is a branch (`id_branch_i`=1) and the EX instruction writes a nonzero `ex_rd_i` equal to either ID source.
- R9: `stall_o` is 1 when the ID instruction is a branch and the MEM instruction is a load writing a nonzero `mem_rd_i` equal to either ID source.
- R10: In every other case `stall_o` is 0. This includes a non-branch ID instruction that reads a load destination held in MEM or WB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | REG_AW | First source register of the instruction in ID |
| id_rs2_i | input | REG_AW | Second source register of the instruction in ID |
| id_branch_i | input | 1 | ID instruction is a conditional branch |
| ex_rs1_i | input | REG_AW | First source register of the instruction in EX |
| ex_rs2_i | input | REG_AW | Second source register of the instruction in EX |
| ex_rd_i | input | REG_AW | Destination register of the instruction in EX |
| ex_we_i | input | 1 | EX instruction writes a register |
| ex_load_i | input | 1 | EX instruction is a load |
| mem_rs2_i | input | REG_AW | Store-data source register of the instruction in MEM |
| mem_rd_i | input | REG_AW | Destination register of the instruction in MEM |
| mem_we_i | input | 1 | MEM instruction writes a register |
| mem_load_i | input | 1 | MEM instruction is a load |
| wb_rd_i | input | REG_AW | Destination register of the instruction in WB |
| wb_we_i | input | 1 | WB instruction writes a register |
| alu_a_sel_o | output | 2 | ALU input A source: 00 register file, 10 MEM stage, 01 WB stage |
| alu_b_sel_o | output | 2 | ALU input B source, same encoding |
| st_data_sel_o | output | 1 | Store data taken from the WB value when 1 |
| br_a_sel_o | output | 2 | Branch comparator operand A source, same encoding |
| br_b_sel_o | output | 2 | Branch comparator operand B source, same encoding |
| stall_o | output | 1 | Hold PC and IF/ID, insert a bubble into EX |

## Verification
Two things can happen in the same cycle. Bypass priority is decided when the MEM and WB producers name the same source. A stall can also be raised while forwarding selects are active for the same registers. The bench provokes both by sweeping every combination of register numbers, write flags and load flags over a 4-register configuration. Each vector is judged against selects and stall values computed from the requirement conditions alone. Each failed check is tagged with the requirement that decided the expected value: priority, no-match, load interlock or branch interlock.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_WB    = 2'b01,
    FWD_MEM   = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              we_i,
  output logic              hit_o
);
  // register 0 is never a producer
  assign hit_o = we_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] near_rd_i,
  input  logic              near_we_i,
  input  logic [REG_AW-1:0] far_rd_i,
  input  logic              far_we_i,
  output fwd_sel_e          sel_o
);
  logic near_hit, far_hit;

  fwd_hit #(.REG_AW(REG_AW)) i_near (
    .src_i(src_i), .dst_i(near_rd_i), .we_i(near_we_i), .hit_o(near_hit)
  );
  fwd_hit #(.REG_AW(REG_AW)) i_far (
    .src_i(src_i), .dst_i(far_rd_i), .we_i(far_we_i), .hit_o(far_hit)
  );

  // younger producer wins
  always_comb begin
    if (near_hit)     sel_o = FWD_MEM;
    else if (far_hit) sel_o = FWD_WB;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/load_use_det.sv
module load_use_det #(
  parameter int REG_AW = 5,
  parameter int N_SRC  = 2
) (
  input  logic [N_SRC-1:0][REG_AW-1:0] id_src_i,
  input  logic                         id_branch_i,
  input  logic [REG_AW-1:0]            ex_rd_i,
  input  logic                         ex_we_i,
  input  logic                         ex_load_i,
  input  logic [REG_AW-1:0]            mem_rd_i,
  input  logic                         mem_we_i,
  input  logic                         mem_load_i,
  output logic                         stall_o
);
  logic [N_SRC-1:0] ex_hit, mem_ld_hit, need_stall;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    fwd_hit #(.REG_AW(REG_AW)) i_ex (
      .src_i(id_src_i[g]), .dst_i(ex_rd_i), .we_i(ex_we_i), .hit_o(ex_hit[g])
    );
    fwd_hit #(.REG_AW(REG_AW)) i_mem (
      .src_i(id_src_i[g]), .dst_i(mem_rd_i), .we_i(mem_we_i && mem_load_i),
      .hit_o(mem_ld_hit[g])
    );
    // load in EX: data too late for any ID consumer
    // branch in ID: compares before EX result or MEM load data exist
    assign need_stall[g] = (ex_hit[g] && ex_load_i)
                         || (id_branch_i && (ex_hit[g] || mem_ld_hit[g]));
  end

  assign stall_o = |need_stall;
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_branch_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        alu_a_sel_o,
  output logic [1:0]        alu_b_sel_o,
  output logic              st_data_sel_o,
  output logic [1:0]        br_a_sel_o,
  output logic [1:0]        br_b_sel_o,
  output logic              stall_o
);
  localparam int N_SRC = 2;

  logic [N_SRC-1:0][REG_AW-1:0] ex_src, id_src;
  fwd_sel_e [N_SRC-1:0]         alu_sel, br_sel;

  assign ex_src = {ex_rs2_i, ex_rs1_i};
  assign id_src = {id_rs2_i, id_rs1_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_op
    fwd_pick #(.REG_AW(REG_AW)) i_alu (
      .src_i(ex_src[g]), .near_rd_i(mem_rd_i), .near_we_i(mem_we_i),
      .far_rd_i(wb_rd_i), .far_we_i(wb_we_i), .sel_o(alu_sel[g])
    );
    fwd_pick #(.REG_AW(REG_AW)) i_br (
      .src_i(id_src[g]), .near_rd_i(mem_rd_i), .near_we_i(mem_we_i),
      .far_rd_i(wb_rd_i), .far_we_i(wb_we_i), .sel_o(br_sel[g])
    );
  end

  // store data in MEM can only be overtaken by WB
  fwd_hit #(.REG_AW(REG_AW)) i_st (
    .src_i(mem_rs2_i), .dst_i(wb_rd_i), .we_i(wb_we_i), .hit_o(st_data_sel_o)
  );

  load_use_det #(.REG_AW(REG_AW), .N_SRC(N_SRC)) i_lud (
    .id_src_i(id_src), .id_branch_i(id_branch_i),
    .ex_rd_i(ex_rd_i), .ex_we_i(ex_we_i), .ex_load_i(ex_load_i),
    .mem_rd_i(mem_rd_i), .mem_we_i(mem_we_i), .mem_load_i(mem_load_i),
    .stall_o(stall_o)
  );

  assign alu_a_sel_o = alu_sel[0];
  assign alu_b_sel_o = alu_sel[1];
  assign br_a_sel_o  = br_sel[0];
  assign br_b_sel_o  = br_sel[1];
endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_rs1_i,
  input logic [REG_AW-1:0] id_rs2_i,
  input logic              id_branch_i,
  input logic [REG_AW-1:0] ex_rs1_i,
  input logic [REG_AW-1:0] ex_rs2_i,
  input logic [REG_AW-1:0] ex_rd_i,
  input logic              ex_we_i,
  input logic              ex_load_i,
  input logic [REG_AW-1:0] mem_rs2_i,
  input logic [REG_AW-1:0] mem_rd_i,
  input logic              mem_we_i,
  input logic              mem_load_i,
  input logic [REG_AW-1:0] wb_rd_i,
  input logic              wb_we_i,
  input logic [1:0]        alu_a_sel_o,
  input logic [1:0]        alu_b_sel_o,
  input logic              st_data_sel_o,
  input logic [1:0]        br_a_sel_o,
  input logic [1:0]        br_b_sel_o,
  input logic              stall_o
);
  always_comb begin
    // R1
    mem_src_a_chk: assert (alu_a_sel_o != 2'b10 || (mem_we_i && mem_rd_i == ex_rs1_i))
      else $error("alu A forwarded from MEM without a match");
    // R4
    no_sel11_chk: assert (alu_a_sel_o != 2'b11 && alu_b_sel_o != 2'b11
                          && br_a_sel_o != 2'b11 && br_b_sel_o != 2'b11)
      else $error("illegal select code");
    // R4
    idle_sel_chk: assert (mem_we_i || wb_we_i ||
                          (alu_a_sel_o == 2'b00 && alu_b_sel_o == 2'b00
                           && br_a_sel_o == 2'b00 && br_b_sel_o == 2'b00))
      else $error("select active with no writing producer");
    // R5
    st_src_chk: assert (!st_data_sel_o || (wb_we_i && wb_rd_i != '0 && wb_rd_i == mem_rs2_i))
      else $error("store data forwarded without a match");
    // R6
    br_wb_chk: assert (br_a_sel_o != 2'b01 || wb_rd_i == id_rs1_i)
      else $error("branch A forwarded from WB without a match");
    // R6
    br_mem_chk: assert (br_b_sel_o != 2'b10 || mem_rd_i == id_rs2_i)
      else $error("branch B forwarded from MEM without a match");
    // R2
    alu_b_wb_chk: assert (alu_b_sel_o != 2'b01 || wb_rd_i == ex_rs2_i)
      else $error("alu B forwarded from WB without a match");
    // R10
    no_cause_stall_chk: assert (!stall_o || id_branch_i || (ex_load_i && ex_we_i))
      else $error("stall without load or branch");
    // R9
    br_stall_chk: assert (!stall_o || ex_load_i || (id_branch_i && (ex_we_i || (mem_load_i && mem_we_i))))
      else $error("branch stall without a producer");
    // R7
    rd0_stall_chk: assert (!stall_o || ex_rd_i != '0 || (mem_load_i && mem_rd_i != '0))
      else $error("stall on register 0");
  end
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.REG_AW(REG_AW)) i_hazard_fwd_chk (.*);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
  localparam int AW = 2;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic id_br, ex_we, ex_ld, mem_we, mem_ld, wb_we;
  logic [1:0] alu_a, alu_b, br_a, br_b;
  logic st_sel, stall;

  int n_tests = 0;
  int n_fail  = 0;

  hazard_fwd_unit #(.REG_AW(AW)) i_hazard_fwd_unit (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_branch_i(id_br),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2), .ex_rd_i(ex_rd),
    .ex_we_i(ex_we), .ex_load_i(ex_ld),
    .mem_rs2_i(mem_rs2), .mem_rd_i(mem_rd), .mem_we_i(mem_we), .mem_load_i(mem_ld),
    .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .alu_a_sel_o(alu_a), .alu_b_sel_o(alu_b), .st_data_sel_o(st_sel),
    .br_a_sel_o(br_a), .br_b_sel_o(br_b), .stall_o(stall)
  );

  function automatic bit produces(int s, int d, bit we);
    return we && (d > 0) && (d == s);
  endfunction

  function automatic int exp_sel(int s, int nd, bit nwe, int fd, bit fwe);
    if (produces(s, nd, nwe)) return 2;
    if (produces(s, fd, fwe)) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int s, int nd, bit nwe, int fd, bit fwe);
    if (produces(s, nd, nwe) && produces(s, fd, fwe)) return "R3";
    if (produces(s, nd, nwe)) return "R1";
    if (produces(s, fd, fwe)) return "R2";
    return "R4";
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic zero_inputs();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_br, ex_we, ex_ld, mem_we, mem_ld, wb_we} = '0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    zero_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle state: nothing forwarded, no stall (R4, R10)
    check("R4 idle alu_a", alu_a, 0);
    check("R4 idle alu_b", alu_b, 0);
    check("R5 idle st", st_sel, 0);
    check("R10 idle stall", stall, 0);
    rst_n = 1'b1;

    // ALU operand sweep: R1 R2 R3 R4
    for (int a = 0; a < NR; a++)
      for (int b = 0; b < NR; b++)
        for (int md = 0; md < NR; md++)
          for (int mw = 0; mw < 2; mw++)
            for (int wd = 0; wd < NR; wd++)
              for (int ww = 0; ww < 2; ww++) begin
                @(negedge clk);
                zero_inputs();
                ex_rs1 = AW'(a); ex_rs2 = AW'(b);
                mem_rd = AW'(md); mem_we = mw[0];
                wb_rd = AW'(wd); wb_we = ww[0];
                #1;
                check({sel_tag(a, md, mw[0], wd, ww[0]), " alu_a"}, alu_a,
                      exp_sel(a, md, mw[0], wd, ww[0]));
                check({sel_tag(b, md, mw[0], wd, ww[0]), " alu_b"}, alu_b,
                      exp_sel(b, md, mw[0], wd, ww[0]));
              end

    // store data sweep: R5
    for (int s = 0; s < NR; s++)
      for (int wd = 0; wd < NR; wd++)
        for (int ww = 0; ww < 2; ww++) begin
          @(negedge clk);
          zero_inputs();
          mem_rs2 = AW'(s); wb_rd = AW'(wd); wb_we = ww[0];
          mem_rd = AW'(s); mem_we = 1'b1;  // MEM producer must not affect store path
          #1;
          check("R5 st_data", st_sel, int'(produces(s, wd, ww[0])));
        end

    // interlock and branch operand sweep: R6 R7 R8 R9 R10
    for (int r1 = 0; r1 < NR; r1++)
      for (int r2 = 0; r2 < NR; r2++)
        for (int br = 0; br < 2; br++)
          for (int ed = 0; ed < NR; ed++)
            for (int ew = 0; ew < 2; ew++)
              for (int el = 0; el < 2; el++)
                for (int md = 0; md < NR; md++)
                  for (int mw = 0; mw < 2; mw++)
                    for (int ml = 0; ml < 2; ml++) begin
                      int  wd;
                      bit  ld_hit, exh, mlh, exp_st;
                      string tag;
                      wd = (r1 + r2 + md) % NR;
                      @(negedge clk);
                      zero_inputs();
                      id_rs1 = AW'(r1); id_rs2 = AW'(r2); id_br = br[0];
                      ex_rd = AW'(ed); ex_we = ew[0]; ex_ld = el[0];
                      mem_rd = AW'(md); mem_we = mw[0]; mem_ld = ml[0];
                      wb_rd = AW'(wd); wb_we = 1'b1;
                      // EX producer sources mirror ID so forwarding and stall coincide
                      ex_rs1 = AW'(r1); ex_rs2 = AW'(r2);
                      #1;
                      exh    = produces(r1, ed, ew[0]) || produces(r2, ed, ew[0]);
                      mlh    = produces(r1, md, mw[0] && ml[0]) || produces(r2, md, mw[0] && ml[0]);
                      ld_hit = exh && el[0];
                      exp_st = ld_hit || (br[0] && (exh || mlh));
                      if (ld_hit)                  tag = "R7";
                      else if (br[0] && exh)       tag = "R8";
                      else if (br[0] && mlh)       tag = "R9";
                      else                         tag = "R10";
                      check({tag, " stall"}, stall, int'(exp_st));
                      check("R6 br_a", br_a, exp_sel(r1, md, mw[0], wd, 1'b1));
                      check("R6 br_b", br_b, exp_sel(r2, md, mw[0], wd, 1'b1));
                      check("R3 alu_a with stall", alu_a, exp_sel(r1, md, mw[0], wd, 1'b1));
                    end

    finish_run();
  end
endmodule